// File: doc/BRIEF.md
# Daisy-Chain Command Frame Encoder

This block turns one command for a chain of battery-monitor devices into a 32-bit serial frame and sends it as an SPI master. A command is a 5-bit device number, a 6-bit register number, an 8-bit payload and a broadcast flag. The encoder mirrors the device number so that it goes out least significant bit first. It packs the fields into fixed positions and appends an 8-bit check code built from three folding steps. The frame is then clocked out most significant bit first in SPI mode 1.

The host offers a command with a valid/ready handshake. The command is latched in the cycle it is accepted, so changes on the command inputs during a frame do not affect it. Chip select stays low for the 32 bits. After chip select returns high, a one-cycle done pulse is raised. The serial clock is the system clock divided by a parameter (half period `HALF_DIV` cycles), so the nominal rate of about 700 kHz can be set for any system clock.

Top module: `cmdf_encoder`

## Requirements
- R1: The frame holds the mirrored device number in bits 31..27, the register number in bits 26..21, the payload in bits 20..13, the broadcast flag in bit 12 and a zero in bit 11.
- R2: The device number is bit-mirrored before packing: input bit 0 appears in frame bit 31 and input bit 4 in frame bit 27.
- R3: Bits 10..3 carry the check code. Take v = frame bits 31..11 as a 24-bit value (upper three bits zero). Let S(x) be the 8-bit MSB-first remainder step of polynomial x^8+x^5+x^3+x^2+x+1 (0x2F) from a zero start. Then the code is S(S(v[23:16]) xor v[15:8]) xor v[7:0].
- R4: Frame bits 2..0 are always 3'b010.
- R5: SPI mode 1: the serial clock idles low whenever chip select is high, and the data line changes only at rising clock edges, never at a falling edge.
- R6: Each chip-select-low window holds exactly 32 falling clock edges, and the bit sampled at the k-th falling edge is frame bit 31-k+1 (MSB first).
- R7: Every serial clock level, the time from chip select falling to the first rising edge, and the time from the last falling edge to chip select rising all last HALF_DIV system cycles. A frame therefore keeps chip select low for 65*HALF_DIV cycles.
- R8: `cmd_ready` is high only while no frame is in progress. A command is taken on a cycle with valid and ready both high. Input changes after that cycle do not alter the frame being sent.
- R9: `frame_done` is high for exactly one cycle: the first cycle in which chip select is high again after a frame.
- R10: While reset is high, the next cycle shows chip select high, serial clock low, done low and ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Encoder idle and able to take a command |
| cmd_dev | input | 5 | Device number in the chain (0 = first device, 31 = highest) |
| cmd_reg | input | 6 | Register number |
| cmd_data | input | 8 | Payload byte |
| cmd_bcast | input | 1 | Broadcast flag |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| frame_done | output | 1 | One-cycle pulse after a frame completes |

## Verification
The assertions assume reset is applied at the start, and that `HALF_DIV` is at least one so every clock level lasts a whole number of system cycles. They also assume the host keeps to the handshake: a command counts only when valid and ready are high together. The bench offers each command only after it has seen ready high. It drops valid in the cycle after acceptance and deliberately scrambles the command inputs while the frame is in flight. The sweeps cover every device number with both flag values, every register number and every payload byte, using a short divider so the full set fits the cycle budget.

// File: rtl/cmdf_pkg.sv
package cmdf_pkg;

  localparam int DEV_W     = 5;
  localparam int REG_W     = 6;
  localparam int DATA_W    = 8;
  localparam int CRC_W     = 8;
  localparam int FRAME_W   = 32;
  localparam int SPAN_W    = 24;
  localparam int BITCNT_W  = $clog2(FRAME_W + 1);
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h2F;
  localparam logic [2:0]       TRAILER  = 3'b010;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_LEAD,
    TX_HIGH,
    TX_LOW,
    TX_FIN,
    TX_GAP
  } tx_state_e;

  // Reverse the bit order of the device number.
  function automatic logic [DEV_W-1:0] mirror_dev(input logic [DEV_W-1:0] a);
    logic [DEV_W-1:0] r;
    for (int i = 0; i < DEV_W; i++) r[DEV_W-1-i] = a[i];
    return r;
  endfunction

  // One byte through the MSB-first remainder register, zero start.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] b);
    logic [CRC_W-1:0] r;
    r = b;
    for (int i = 0; i < 8; i++)
      r = r[CRC_W-1] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction

endpackage

// File: rtl/cmdf_crc8.sv
module cmdf_crc8
  import cmdf_pkg::*;
(
  input  logic [SPAN_W-1:0] span,
  output logic [CRC_W-1:0]  code
);
  // Named intermediate stages of the three-step fold.
  logic [CRC_W-1:0] stage_top;
  logic [CRC_W-1:0] stage_mid;

  always_comb begin
    stage_top = crc_step(span[23:16]);
    stage_mid = crc_step(stage_top ^ span[15:8]);
    code      = stage_mid ^ span[7:0];
  end
endmodule

// File: rtl/cmdf_packer.sv
module cmdf_packer
  import cmdf_pkg::*;
(
  input  logic [DEV_W-1:0]   dev,
  input  logic [REG_W-1:0]   regn,
  input  logic [DATA_W-1:0]  data,
  input  logic               bcast,
  output logic [FRAME_W-1:0] word
);
  logic [DEV_W-1:0]  dev_mirrored;
  logic [20:0]       head;
  logic [SPAN_W-1:0] span;
  logic [CRC_W-1:0]  code;

  assign dev_mirrored = mirror_dev(dev);
  // head is frame bits 31..11; bit 11 is always zero
  assign head = {dev_mirrored, regn, data, bcast, 1'b0};
  assign span = {3'b000, head};

  cmdf_crc8 u_crc (
    .span (span),
    .code (code)
  );

  assign word = {head, code, TRAILER};
endmodule

// File: rtl/cmdf_spi_tx.sv
module cmdf_spi_tx
  import cmdf_pkg::*;
#(
  parameter int HALF_DIV = 36
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] word,
  output logic               idle,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  output logic               done
);
  localparam int DIV_W = $clog2(HALF_DIV + 1);

  tx_state_e            state;
  logic [DIV_W-1:0]     div_cnt;
  logic [BITCNT_W-1:0]  bit_cnt;
  logic [FRAME_W-1:0]   shreg;
  logic                 sclk_q;
  logic                 cs_q;

  // Internal events brought out as named wires.
  logic half_elapsed;
  logic last_bit;

  assign half_elapsed = (div_cnt == DIV_W'(HALF_DIV - 1));
  assign last_bit     = (bit_cnt == BITCNT_W'(FRAME_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= TX_IDLE;
      div_cnt <= '0;
      bit_cnt <= '0;
      shreg   <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
    end else begin
      case (state)
        TX_IDLE: begin
          if (load) begin
            shreg   <= word;
            cs_q    <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            state   <= TX_LEAD;
          end
        end
        TX_LEAD: begin
          if (half_elapsed) begin
            div_cnt <= '0;
            sclk_q  <= 1'b1;
            state   <= TX_HIGH;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        TX_HIGH: begin
          if (half_elapsed) begin
            div_cnt <= '0;
            sclk_q  <= 1'b0;
            bit_cnt <= bit_cnt + 1'b1;
            state   <= TX_LOW;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        TX_LOW: begin
          if (half_elapsed) begin
            div_cnt <= '0;
            if (last_bit) begin
              cs_q  <= 1'b1;
              state <= TX_FIN;
            end else begin
              sclk_q <= 1'b1;
              shreg  <= shreg << 1;
              state  <= TX_HIGH;
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        TX_FIN: begin
          div_cnt <= '0;
          state   <= TX_GAP;
        end
        TX_GAP: begin
          if (half_elapsed) begin
            div_cnt <= '0;
            state   <= TX_IDLE;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign idle = (state == TX_IDLE);
  assign done = (state == TX_FIN);
  assign sclk = sclk_q;
  assign cs_n = cs_q;
  assign mosi = shreg[FRAME_W-1];
endmodule

// File: rtl/cmdf_encoder.sv
module cmdf_encoder
  import cmdf_pkg::*;
#(
  parameter int HALF_DIV = 36
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [4:0]  cmd_dev,
  input  logic [5:0]  cmd_reg,
  input  logic [7:0]  cmd_data,
  input  logic        cmd_bcast,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  output logic        frame_done
);
  logic [FRAME_W-1:0] frame_word;
  logic               tx_idle;
  logic               accept;

  assign cmd_ready = tx_idle;
  assign accept    = cmd_valid && tx_idle;

  cmdf_packer u_pack (
    .dev   (cmd_dev),
    .regn  (cmd_reg),
    .data  (cmd_data),
    .bcast (cmd_bcast),
    .word  (frame_word)
  );

  cmdf_spi_tx #(.HALF_DIV(HALF_DIV)) u_tx (
    .clk  (clk),
    .rst  (rst),
    .load (accept),
    .word (frame_word),
    .idle (tx_idle),
    .sclk (spi_sclk),
    .cs_n (spi_cs_n),
    .mosi (spi_mosi),
    .done (frame_done)
  );
endmodule

// File: rtl/cmdf_encoder_checker.sv
module cmdf_encoder_checker #(
  parameter int HALF_DIV = 36
) (
  input logic clk,
  input logic rst,
  input logic cmd_ready,
  input logic spi_sclk,
  input logic spi_cs_n,
  input logic spi_mosi,
  input logic frame_done
);
  logic        prev_sclk;
  logic        prev_cs_n;
  logic [15:0] run_len;
  logic [7:0]  fall_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sclk <= 1'b0;
      prev_cs_n <= 1'b1;
      run_len   <= '0;
      fall_cnt  <= '0;
    end else begin
      prev_sclk <= spi_sclk;
      prev_cs_n <= spi_cs_n;
      if (spi_sclk != prev_sclk || spi_cs_n != prev_cs_n)
        run_len <= 16'd1;
      else if (run_len != 16'hFFFF)
        run_len <= run_len + 1'b1;
      if (spi_cs_n && !prev_cs_n)
        fall_cnt <= '0;
      else if (!spi_sclk && prev_sclk && !spi_cs_n)
        fall_cnt <= fall_cnt + 1'b1;
    end
  end

  // R10
  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> (spi_cs_n && !spi_sclk && !frame_done && cmd_ready));

  // R5
  a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  // R5
  a_r5_mosi_still_at_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_sclk) |-> $stable(spi_mosi));

  // R6
  a_r6_thirty_two_falls: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && !prev_cs_n) |-> (fall_cnt == 8'd32));

  // R7
  a_r7_sclk_half_period: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk != prev_sclk) |-> (run_len == 16'(HALF_DIV)));

  // R7
  a_r7_cs_tail: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && !prev_cs_n) |-> (run_len == 16'(HALF_DIV)));

  // R8
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> !cmd_ready);

  // R9
  a_r9_done_on_cs_rise: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (spi_cs_n && !prev_cs_n));

  // R9
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R9
  a_r9_cs_rise_gives_done: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && !prev_cs_n) |-> frame_done);
endmodule

bind cmdf_encoder cmdf_encoder_checker #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_ready  (cmd_ready),
  .spi_sclk   (spi_sclk),
  .spi_cs_n   (spi_cs_n),
  .spi_mosi   (spi_mosi),
  .frame_done (frame_done)
);

// File: tb/cmdf_encoder_test.sv
module cmdf_encoder_test;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       cmd_valid = 1'b0;
  logic [4:0] cmd_dev   = '0;
  logic [5:0] cmd_reg   = '0;
  logic [7:0] cmd_data  = '0;
  logic       cmd_bcast = 1'b0;
  wire        cmd_ready, spi_sclk, spi_cs_n, spi_mosi, frame_done;

  cmdf_encoder #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dev(cmd_dev), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
    .cmd_bcast(cmd_bcast), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .frame_done(frame_done)
  );

  int checks = 0;
  int errors = 0;

  // Slave model, sampled between clock edges.
  logic [31:0] cap = '0;
  int          nbits = 0;
  int          low_cycles = 0;
  logic        seen_sclk = 1'b0;
  logic        seen_cs_n = 1'b1;

  always @(negedge clk) begin
    if (!spi_cs_n && seen_cs_n) begin
      cap = '0; nbits = 0; low_cycles = 0;
    end
    if (!spi_cs_n) low_cycles++;
    if (!spi_cs_n && seen_sclk && !spi_sclk) begin
      cap = {cap[30:0], spi_mosi};
      nbits++;
    end
    seen_sclk = spi_sclk;
    seen_cs_n = spi_cs_n;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Remainder of {x, 8'h00} by the degree-8 polynomial, by long division.
  function automatic logic [7:0] rem_step(input logic [7:0] x);
    logic [15:0] r;
    r = {x, 8'h00};
    for (int i = 15; i >= 8; i--)
      if (r[i]) r = r ^ (16'h012F << (i - 8));
    return r[7:0];
  endfunction

  function automatic logic [31:0] expect_frame(input int dev, input int regn,
                                               input int data, input int b);
    int m;
    logic [31:0] w;
    logic [23:0] v;
    logic [7:0]  c;
    m = 0;
    for (int i = 0; i < 5; i++) if ((dev >> i) & 1) m = m + (1 << (4 - i));
    w = (32'(m) << 27) + (32'(regn) << 21) + (32'(data) << 13) + (32'(b) << 12);
    v = 24'(w >> 11);
    c = rem_step(rem_step(v[23:16]) ^ v[15:8]) ^ v[7:0];
    return w + (32'(c) << 3) + 32'd2;
  endfunction

  task automatic send(input int dev, input int regn, input int data,
                      input int b, input string req);
    logic [31:0] exp;
    exp = expect_frame(dev, regn, data, b);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_dev = 5'(dev); cmd_reg = 6'(regn); cmd_data = 8'(data);
    cmd_bcast = b[0]; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    // R8: scramble inputs mid-frame; frame must not change
    cmd_dev = ~cmd_dev; cmd_reg = ~cmd_reg; cmd_data = ~cmd_data;
    cmd_bcast = ~cmd_bcast;
    check(cmd_ready == 1'b0, "R8 ready low while busy", 32'(cmd_ready), 32'd0);
    while (!frame_done) @(negedge clk);
    check(cap == exp, req, cap, exp);
    check(cap[2:0] == 3'b010 && cap[11] == 1'b0, "R4 trailer", 32'(cap[2:0]), 32'd2);
    check(nbits == 32, "R6 bit count", 32'(nbits), 32'd32);
    check(low_cycles == 65 * HALF, "R7 cs low length", 32'(low_cycles), 32'(65 * HALF));
    check(spi_cs_n == 1'b1, "R9 done with cs high", 32'(spi_cs_n), 32'd1);
    @(negedge clk);
    check(frame_done == 1'b0, "R9 done single cycle", 32'(frame_done), 32'd0);
  endtask

  initial begin
    repeat (200000 - 10000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(spi_cs_n == 1'b1, "R10 cs idle", 32'(spi_cs_n), 32'd1);
    check(spi_sclk == 1'b0, "R10 sclk idle", 32'(spi_sclk), 32'd0);
    check(cmd_ready == 1'b1, "R10 ready", 32'(cmd_ready), 32'd1);
    check(frame_done == 1'b0, "R10 done low", 32'(frame_done), 32'd0);

    // R2 R1 R3: every device number, both broadcast values
    for (int d = 0; d < 32; d++)
      for (int b = 0; b < 2; b++)
        send(d, 6'h1C, (d * 7) & 8'hFF, b, "R2 mirrored device frame");
    // R1 R3: every register number at the highest device
    for (int r = 0; r < 64; r++)
      send(31, r, 8'hA5, 0, "R1 register field frame");
    // R3 R5: every payload byte
    for (int x = 0; x < 256; x++)
      send(0, 6'h0D, x, 1, "R3 payload and check code frame");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule